// File: doc/BRIEF.md
# Program Sequencer with Table-Read Pointer

This unit is the instruction-fetch and program-flow stage of a small 4-bit microcontroller that uses 10-bit instruction words. It holds a 12-bit program counter and a two-entry return stack. It drives a single 15-bit ROM address port. During fetches that port carries the zero-extended program counter. During table reads it carries a separately loaded 15-bit table pointer, so table reads can reach the whole 32K-word space while code is confined to the low 4K words.

The pipeline has two stages. While one instruction executes, the word after it is fetched. The instruction decoder sits outside the block and returns one-cycle strobes for jump, call, return, table read and pointer write during the cycle in which the instruction is on `execInstr`. A taken jump, call or return throws away the word already fetched and inserts one bubble. A table read also inserts one bubble, and in that bubble the ROM is addressed by the pointer and the word is captured into `tblData`. The ROM is combinational: `romData` answers the address on `romAddr` in the same cycle.

Top module: `prog_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `romAddr` is 0, `execInstr` is the no-op word 10'h000, `bubble` is 1 and `tblData` is 0.
- R2: In a cycle with no bubble and no strobe, `romAddr[14:12]` is 0. `romAddr[11:0]` is one more than in the previous cycle, and the word fetched there appears on `execInstr` in the next cycle.
- R3: A jump strobe makes the next cycle a bubble (`bubble`=1, `execInstr`=10'h000) that fetches from `target`. The target word executes in the cycle after that bubble.
- R4: A call pushes the address that follows the call instruction and then jumps to `target`. A return jumps back to the most recently pushed address. Both take one bubble, and two nested calls come back in last-in, first-out order.
- R5: A third nested call discards the oldest stack entry. Once the stack has been emptied, a further return goes again to the last address popped.
- R6: A table read makes the next cycle a bubble in which `romAddr` equals the full 15-bit pointer. The word read there is held on `tblData` from the following cycle on. The program counter does not advance during that bubble, so the instruction that follows the table read then executes.
- R7: A pointer write stores `ptrNib` into one field of the pointer. `ptrSel` 0 selects bits 3:0, 1 selects bits 7:4, 2 selects bits 11:8, and 3 selects bits 14:12 from `ptrNib[2:0]`. Fields that are not written keep their values, so a partly written pointer is used as it stands.
- R8: Every strobe, pointer writes included, is ignored in a bubble cycle.
- R9: When several flow strobes arrive together, return wins over call, call over jump, and jump over table read.
- R10: The program counter wraps from 12'hFFF to 12'h000 when it advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| jumpEn | input | 1 | Decoded jump strobe |
| callEn | input | 1 | Decoded call strobe |
| retEn | input | 1 | Decoded return strobe |
| tblRdEn | input | 1 | Decoded table-read strobe |
| target | input | 12 | Jump or call destination |
| ptrWrEn | input | 1 | Table pointer field write strobe |
| ptrSel | input | 2 | Pointer field select |
| ptrNib | input | 4 | Nibble from the internal data bus |
| romData | input | 10 | ROM word at `romAddr` |
| romAddr | output | 15 | ROM address, fetch or table read |
| execInstr | output | 10 | Instruction in the execute stage, 10'h000 in a bubble |
| bubble | output | 1 | The execute stage holds a bubble |
| tblData | output | 10 | Last word returned by a table read |

## Verification
The case that is hardest to reach from the ports is a strobe arriving during a bubble while the return stack is already full. It needs a call chain three deep, then returns that go past the empty point, with a conflicting jump or pointer write placed exactly in one of the bubble cycles. Directed sequences build that chain with explicit targets and put conflicting strobes into the bubbles on purpose. A seeded random phase then fires strobes in every cycle, bubbles included, and compares each cycle against a bench reference model.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_BR_BUB  = 2'd1,
    ST_TBL_BUB = 2'd2
  } seqState_e;

  // Strobes passed from the control FSM to the datapath.
  typedef struct packed {
    logic pcLoadTgt;
    logic pcLoadTop;
    logic pcInc;
    logic push;
    logic pop;
    logic irLoad;
    logic tblLoad;
    logic usePtr;
    logic ptrWrite;
    logic hideIr;
  } seqCtl_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    jumpEn,
  input  logic    callEn,
  input  logic    retEn,
  input  logic    tblRdEn,
  input  logic    ptrWrEn,
  output seqCtl_t ctl,
  output logic    bubble
);

  seqState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_BR_BUB;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctl    = '0;
    stateD = ST_RUN;
    unique case (stateQ)
      ST_RUN: begin
        ctl.ptrWrite = ptrWrEn;
        if (retEn) begin
          ctl.pcLoadTop = 1'b1;
          ctl.pop       = 1'b1;
          stateD        = ST_BR_BUB;
        end else if (callEn) begin
          ctl.pcLoadTgt = 1'b1;
          ctl.push      = 1'b1;
          stateD        = ST_BR_BUB;
        end else if (jumpEn) begin
          ctl.pcLoadTgt = 1'b1;
          stateD        = ST_BR_BUB;
        end else if (tblRdEn) begin
          ctl.irLoad = 1'b1;
          ctl.pcInc  = 1'b1;
          stateD     = ST_TBL_BUB;
        end else begin
          ctl.irLoad = 1'b1;
          ctl.pcInc  = 1'b1;
        end
      end
      ST_BR_BUB: begin
        ctl.hideIr = 1'b1;
        ctl.irLoad = 1'b1;
        ctl.pcInc  = 1'b1;
      end
      ST_TBL_BUB: begin
        ctl.hideIr  = 1'b1;
        ctl.usePtr  = 1'b1;
        ctl.tblLoad = 1'b1;
      end
      default: begin
        ctl.hideIr = 1'b1;
        stateD     = ST_BR_BUB;
      end
    endcase
  end

  assign bubble = (stateQ != ST_RUN);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int ADDR_W      = 15,
  parameter int WORD_W      = 10,
  parameter int NIB_W       = 4,
  parameter int STACK_DEPTH = 2,
  parameter logic [WORD_W-1:0] NOP_WORD = '0,
  localparam int NIB_CNT    = (ADDR_W + NIB_W - 1) / NIB_W,
  localparam int SEL_W      = (NIB_CNT > 1) ? $clog2(NIB_CNT) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [PC_W-1:0]   target,
  input  logic [SEL_W-1:0]  ptrSel,
  input  logic [NIB_W-1:0]  ptrNib,
  input  logic [WORD_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [WORD_W-1:0] execInstr,
  output logic [WORD_W-1:0] tblData
);

  logic [PC_W-1:0]   pcQ;
  logic [PC_W-1:0]   stackQ [STACK_DEPTH];
  logic [ADDR_W-1:0] ptrQ;
  logic [WORD_W-1:0] irQ;
  logic [WORD_W-1:0] tblQ;

  // Program counter: return, jump/call target or increment.
  always_ff @(posedge clk) begin
    if (!rstN)              pcQ <= '0;
    else if (ctl.pcLoadTop) pcQ <= stackQ[0];
    else if (ctl.pcLoadTgt) pcQ <= target;
    else if (ctl.pcInc)     pcQ <= pcQ + 1'b1;
  end

  // Return stack; the deepest entry is kept on a pop.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STACK_DEPTH; i++) stackQ[i] <= '0;
    end else if (ctl.push) begin
      stackQ[0] <= pcQ;
      for (int i = 1; i < STACK_DEPTH; i++) stackQ[i] <= stackQ[i-1];
    end else if (ctl.pop) begin
      for (int i = 0; i < STACK_DEPTH - 1; i++) stackQ[i] <= stackQ[i+1];
    end
  end

  // Table pointer, one field per write.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_ptrBit
    always_ff @(posedge clk) begin
      if (!rstN)
        ptrQ[b] <= 1'b0;
      else if (ctl.ptrWrite && (ptrSel == SEL_W'(b / NIB_W)))
        ptrQ[b] <= ptrNib[b % NIB_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           irQ <= NOP_WORD;
    else if (ctl.irLoad) irQ <= romData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            tblQ <= '0;
    else if (ctl.tblLoad) tblQ <= romData;
  end

  assign romAddr   = ctl.usePtr ? ptrQ : ADDR_W'(pcQ);
  assign execInstr = ctl.hideIr ? NOP_WORD : irQ;
  assign tblData   = tblQ;

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
  import seq_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int ADDR_W      = 15,
  parameter int WORD_W      = 10,
  parameter int NIB_W       = 4,
  parameter int STACK_DEPTH = 2,
  localparam int NIB_CNT    = (ADDR_W + NIB_W - 1) / NIB_W,
  localparam int SEL_W      = (NIB_CNT > 1) ? $clog2(NIB_CNT) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              jumpEn,
  input  logic              callEn,
  input  logic              retEn,
  input  logic              tblRdEn,
  input  logic [PC_W-1:0]   target,
  input  logic              ptrWrEn,
  input  logic [SEL_W-1:0]  ptrSel,
  input  logic [NIB_W-1:0]  ptrNib,
  input  logic [WORD_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [WORD_W-1:0] execInstr,
  output logic              bubble,
  output logic [WORD_W-1:0] tblData
);

  seqCtl_t ctl;

  seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .jumpEn  (jumpEn),
    .callEn  (callEn),
    .retEn   (retEn),
    .tblRdEn (tblRdEn),
    .ptrWrEn (ptrWrEn),
    .ctl     (ctl),
    .bubble  (bubble)
  );

  seq_datapath #(
    .PC_W        (PC_W),
    .ADDR_W      (ADDR_W),
    .WORD_W      (WORD_W),
    .NIB_W       (NIB_W),
    .STACK_DEPTH (STACK_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .target    (target),
    .ptrSel    (ptrSel),
    .ptrNib    (ptrNib),
    .romData   (romData),
    .romAddr   (romAddr),
    .execInstr (execInstr),
    .tblData   (tblData)
  );

endmodule

// File: rtl/prog_sequencer_chk.sv
module prog_sequencer_chk #(
  parameter int PC_W   = 12,
  parameter int ADDR_W = 15,
  parameter int WORD_W = 10
)(
  input logic              clk,
  input logic              rstN,
  input logic              jumpEn,
  input logic              callEn,
  input logic              retEn,
  input logic              tblRdEn,
  input logic [PC_W-1:0]   target,
  input logic [ADDR_W-1:0] romAddr,
  input logic [WORD_W-1:0] execInstr,
  input logic              bubble
);

  logic quiet;
  assign quiet = !bubble && !jumpEn && !callEn && !retEn && !tblRdEn;

  a_r2_seq_fetch: assert property (@(posedge clk) disable iff (!rstN)
    quiet |=> (romAddr[PC_W-1:0] == $past(romAddr[PC_W-1:0]) + 1'b1) &&
              (romAddr[ADDR_W-1:PC_W] == '0));

  a_r3_jump_target: assert property (@(posedge clk) disable iff (!rstN)
    (!bubble && jumpEn && !callEn && !retEn) |=>
      bubble && (romAddr == ADDR_W'($past(target))) && (execInstr == '0));

  a_r4_ret_bubble: assert property (@(posedge clk) disable iff (!rstN)
    (!bubble && retEn) |=> bubble);

  a_r6_tbl_bubble: assert property (@(posedge clk) disable iff (!rstN)
    (!bubble && tblRdEn && !jumpEn && !callEn && !retEn) |=> bubble);

  a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(!bubble && tblRdEn && !jumpEn && !callEn && !retEn) |=>
      romAddr[PC_W-1:0] == $past(romAddr[PC_W-1:0], 2) + 1'b1);

  a_r8_single_bubble: assert property (@(posedge clk) disable iff (!rstN)
    bubble |=> !bubble);

endmodule

bind prog_sequencer prog_sequencer_chk #(
  .PC_W(PC_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rstN(rstN), .jumpEn(jumpEn), .callEn(callEn), .retEn(retEn),
  .tblRdEn(tblRdEn), .target(target), .romAddr(romAddr),
  .execInstr(execInstr), .bubble(bubble)
);

// File: tb/prog_sequencer_tb.sv
`timescale 1ns/1ps
module prog_sequencer_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        jumpEn, callEn, retEn, tblRdEn, ptrWrEn;
  logic [11:0] target;
  logic [1:0]  ptrSel;
  logic [3:0]  ptrNib;
  logic [9:0]  romData;
  logic [14:0] romAddr;
  logic [9:0]  execInstr;
  logic        bubble;
  logic [9:0]  tblData;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prog_sequencer u_dut (
    .clk(clk), .rstN(rstN), .jumpEn(jumpEn), .callEn(callEn), .retEn(retEn),
    .tblRdEn(tblRdEn), .target(target), .ptrWrEn(ptrWrEn), .ptrSel(ptrSel),
    .ptrNib(ptrNib), .romData(romData), .romAddr(romAddr),
    .execInstr(execInstr), .bubble(bubble), .tblData(tblData)
  );

  function automatic logic [9:0] romWord(logic [14:0] a);
    logic [31:0] h;
    h = {17'd0, a} * 32'd2654435761;
    return h[25:16] ^ a[9:0] ^ {5'd0, a[14:10]};
  endfunction

  assign romData = romWord(romAddr);

  // Reference model. bub: 0 run, 1 branch bubble, 2 table bubble.
  logic [11:0] mPc, mStk0, mStk1;
  logic [14:0] mPtr;
  logic [9:0]  mIr, mTbl;
  int          mBub;

  task automatic chk(string tag, int got, int exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk({tag, " romAddr"}, romAddr, (mBub == 2) ? mPtr : {3'b0, mPc});
    chk({tag, " execInstr"}, execInstr, (mBub != 0) ? 10'h000 : mIr);
    chk({tag, " bubble"}, bubble, (mBub != 0) ? 1 : 0);
    chk({tag, " tblData"}, tblData, mTbl);
  endtask

  task automatic step(string tag, bit j, bit c, bit r, bit t, logic [11:0] tg,
                      bit pw, logic [1:0] ps, logic [3:0] pn);
    logic [11:0] nPc, nS0, nS1;
    logic [14:0] nPtr;
    logic [9:0]  nIr, nTbl;
    int          nBub;
    jumpEn = j; callEn = c; retEn = r; tblRdEn = t; target = tg;
    ptrWrEn = pw; ptrSel = ps; ptrNib = pn;
    nPc = mPc; nS0 = mStk0; nS1 = mStk1; nPtr = mPtr; nIr = mIr; nTbl = mTbl;
    nBub = 0;
    if (mBub == 0) begin
      if (pw) begin
        case (ps)
          2'd0: nPtr[3:0]   = pn;
          2'd1: nPtr[7:4]   = pn;
          2'd2: nPtr[11:8]  = pn;
          default: nPtr[14:12] = pn[2:0];
        endcase
      end
      if (r) begin
        nPc = mStk0; nS0 = mStk1; nBub = 1;
      end else if (c) begin
        nS1 = mStk0; nS0 = mPc; nPc = tg; nBub = 1;
      end else if (j) begin
        nPc = tg; nBub = 1;
      end else if (t) begin
        nIr = romWord({3'b0, mPc}); nPc = mPc + 12'd1; nBub = 2;
      end else begin
        nIr = romWord({3'b0, mPc}); nPc = mPc + 12'd1;
      end
    end else if (mBub == 1) begin
      nIr = romWord({3'b0, mPc}); nPc = mPc + 12'd1;
    end else begin
      nTbl = romWord(mPtr);
    end
    @(posedge clk);
    @(negedge clk);
    mPc = nPc; mStk0 = nS0; mStk1 = nS1; mPtr = nPtr; mIr = nIr; mTbl = nTbl;
    mBub = nBub;
    checkAll(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 12'h0, 0, 2'd0, 4'h0);
  endtask

  task automatic doJump(string tag, logic [11:0] tg);
    step(tag, 1, 0, 0, 0, tg, 0, 2'd0, 4'h0);
  endtask

  task automatic doCall(string tag, logic [11:0] tg);
    step(tag, 0, 1, 0, 0, tg, 0, 2'd0, 4'h0);
  endtask

  task automatic doRet(string tag);
    step(tag, 0, 0, 1, 0, 12'h0, 0, 2'd0, 4'h0);
  endtask

  task automatic wrPtr(string tag, logic [1:0] s, logic [3:0] n);
    step(tag, 0, 0, 0, 0, 12'h0, 1, s, n);
  endtask

  task automatic doTbl(string tag);
    step(tag, 0, 0, 0, 1, 12'h0, 0, 2'd0, 4'h0);
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20251));
    rstN = 0; jumpEn = 0; callEn = 0; retEn = 0; tblRdEn = 0;
    target = '0; ptrWrEn = 0; ptrSel = '0; ptrNib = '0;
    mPc = 0; mStk0 = 0; mStk1 = 0; mPtr = 0; mIr = 0; mTbl = 0; mBub = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll("R1 in reset");
    rstN = 1;
    checkAll("R1 after release");

    idle("R2 sequential", 6);

    doJump("R3 jump", 12'h345);
    idle("R3 target", 3);

    doJump("R10 near top", 12'hFFE);
    idle("R10 wrap", 4);

    doCall("R4 call A", 12'h100);
    idle("R4 in A", 2);
    doCall("R4 call B", 12'h200);
    idle("R4 in B", 2);
    doRet("R4 ret B");
    idle("R4 back in A", 2);
    doRet("R4 ret A");
    idle("R4 back main", 2);

    doCall("R5 call 1", 12'h400);
    idle("R5 in 1", 1);
    doCall("R5 call 2", 12'h500);
    idle("R5 in 2", 1);
    doCall("R5 call 3", 12'h600);
    idle("R5 in 3", 1);
    doRet("R5 ret 3");
    idle("R5 after ret 3", 1);
    doRet("R5 ret 2");
    idle("R5 after ret 2", 1);
    doRet("R5 empty ret");
    idle("R5 after empty ret", 2);

    wrPtr("R7 sel0", 2'd0, 4'hF);
    wrPtr("R7 sel1", 2'd1, 4'hF);
    wrPtr("R7 sel2", 2'd2, 4'hF);
    wrPtr("R7 sel3", 2'd3, 4'hF);
    doTbl("R6 full ptr");
    idle("R6 after table read", 3);
    wrPtr("R7 partial", 2'd0, 4'h5);
    doTbl("R6 partial ptr");
    idle("R6 after partial", 2);

    doJump("R8 jump", 12'h700);
    step("R8 jump in bubble", 1, 0, 0, 0, 12'h0AB, 1, 2'd3, 4'h2);
    idle("R8 ignored", 2);
    doTbl("R8 table");
    step("R8 call in table bubble", 0, 1, 0, 0, 12'h0CD, 0, 2'd0, 4'h0);
    idle("R8 after", 2);

    doCall("R9 setup", 12'h050);
    idle("R9 setup", 1);
    step("R9 ret wins", 1, 1, 1, 1, 12'h777, 0, 2'd0, 4'h0);
    idle("R9", 1);
    step("R9 call wins", 1, 1, 0, 1, 12'h111, 0, 2'd0, 4'h0);
    idle("R9", 1);
    step("R9 jump wins", 1, 0, 0, 1, 12'h222, 0, 2'd0, 4'h0);
    idle("R9", 2);

    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom % 16;
      step("R2 random", k == 0, k == 1, k == 2, k == 3, 12'($urandom),
           ($urandom % 4) == 0, 2'($urandom), 4'($urandom));
    end

    finishRun();
  end

endmodule